// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous, pipelined static memory with a shared data bus. Reads and writes can be issued back to back in any mix, and the bus never needs an idle cycle. Each word is 36 bits wide. It is split into four byte lanes, and each lane holds eight data bits and one parity bit. The depth is set by a parameter. The bus is modelled as three signals: an input word, an output word and an output-enable.

A read returns its data one recognized clock after its address. A write takes its data from the bus two recognized clocks after its address. The write's address, control and byte mask travel down a two-stage pipeline to the edge where the data is captured. A read that is issued right after a write to the same word is served from the bus data captured at that same edge, so a read always returns the latest contents. A high clock enable freezes the whole pipeline. Output drive is gated by an asynchronous output enable and by the internal read phase.

Top module: `zt_sram`

## Requirements
- R1: An access is sampled at a recognized edge (`clk_en_n`=0) when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. `wr_n`=1 makes it a read and `wr_n`=0 makes it a write.
- R2: For a read sampled at edge N, `dq_out` holds the addressed word and `dq_oe`=1 after recognized edge N+1, provided `out_en_n`=0.
- R3: For a write sampled at edge N, `dq_oe`=0 after edge N+1 whatever the level of `out_en_n`, and `dq_in` is written into the array at edge N+2.
- R4: A read, write or deselect can be issued at every recognized edge. Write-to-read and read-to-write sequences run with no dead cycles.
- R5: `lane_wr_n[i]`=0 writes data bits `dq_in[8i+7:8i]` and parity bit `dq_in[32+i]`. A write with all four selects at 1 changes nothing, and lanes that are not selected keep their contents.
- R6: The byte mask is sampled with the write's address. It is carried to the data-capture edge, and `lane_wr_n` at the capture edge has no effect on that write.
- R7: With `clk_en_n`=1 the edge is ignored. All pipeline state, `dq_out` and `dq_oe` hold their values, and the device is not deselected even if the chip selects are inactive.
- R8: If any chip select is inactive at edge N, `dq_oe`=0 after edge N+1.
- R9: `out_en_n`=1 forces `dq_oe`=0 at once, without any clock. With `out_en_n`=0, `dq_oe` follows the internal read phase.
- R10: A read of the word that a write captures at the same edge returns the newly captured lanes, taken lane by lane under that write's mask, and returns the old contents in the other lanes.
- R11: Reset (`rst`=1 at a clock edge) clears every pipeline valid bit and the read phase, leaving the bus undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high suspends |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write enable, active low |
| lane_wr_n | input | LANES | Byte-lane write selects, active low |
| addr | input | AW | Word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Bus input word: data in [31:0], lane parity in [35:32] |
| dq_out | output | 36 | Registered read word, same layout |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions check on every cycle that a frozen edge changes no pipeline state, and that a write's mask reaches the capture stage unchanged. They also check that the bus is never driven while a write's data phase is open, that a read phase begins only from a sampled read, and that a deselect drops the drive one edge later. Data correctness cannot be seen by a property. This covers read-after-write forwarding, lane merging, ignored empty writes and data that survives a suspension. Only the bench's scenarios, which compare returned words with values computed by hand, can show these.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             sel,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  output op_e              s1_op,
  output logic [AW-1:0]    s1_addr,
  output logic [LANES-1:0] s1_mask,
  output op_e              s2_op,
  output logic [AW-1:0]    s2_addr,
  output logic [LANES-1:0] s2_mask
);
  // Stage 1: address/control phase. Stage 2: write data phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op <= OP_NONE;
      s2_op <= OP_NONE;
    end else if (adv) begin
      if (!sel)      s1_op <= OP_NONE;
      else if (wr_n) s1_op <= OP_RD;
      else           s1_op <= OP_WR;
      s2_op <= (s1_op == OP_WR) ? OP_WR : OP_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_addr <= addr;
      s1_mask <= ~lane_wr_n;
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
    end
  end

  // R7: an ignored edge leaves both stages unchanged
  a_r7_suspend_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(s1_op) && $stable(s2_op)));

  // R6: the mask sampled with the address reaches the data phase intact
  a_r6_mask_carry: assert property (@(posedge clk) disable iff (rst)
    (adv && s1_op == OP_WR) |=> (s2_op == OP_WR && s2_mask == $past(s1_mask)));
endmodule

// File: rtl/zt_sram_lane.sv
module zt_sram_lane #(
  parameter int AW = 10,
  parameter int W  = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          adv,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];
  logic         hit;

  assign hit = we && (waddr == raddr);

  always_ff @(posedge clk) begin
    if (adv && we) mem[waddr] <= wdata;
  end

  // Registered read; a same-edge write to the same word is bypassed.
  always_ff @(posedge clk) begin
    if (adv && re) q <= hit ? wdata : mem[raddr];
  end
endmodule

// File: rtl/zt_sram_outctl.sv
module zt_sram_outctl (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic s1_rd,
  input  logic s2_wr,
  input  logic out_en_n,
  output logic rd_phase,
  output logic dq_oe
);
  always_ff @(posedge clk) begin
    if (rst)      rd_phase <= 1'b0;
    else if (adv) rd_phase <= s1_rd;
  end

  assign dq_oe = rd_phase & ~out_en_n;

  // R3: never drive while a write's data phase is open
  a_r3_write_phase_hiz: assert property (@(posedge clk) disable iff (rst)
    s2_wr |-> !dq_oe);

  // R2: a read phase can only start from a sampled read
  a_r2_phase_from_read: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_phase) |-> $past(s1_rd));
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LANE_W = BYTE_W + 1,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [AW-1:0]     addr,
  input  logic              out_en_n,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);
  logic             adv, sel, s1_rd, s2_wr, rd_phase;
  op_e              s1_op, s2_op;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_mask, s2_mask;

  assign adv   = ~clk_en_n;
  assign sel   = ~sel1_n & sel2 & ~sel3_n;
  assign s1_rd = (s1_op == OP_RD);
  assign s2_wr = (s2_op == OP_WR);

  zt_sram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .adv(adv), .sel(sel), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .addr(addr),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_mask(s1_mask),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_mask(s2_mask)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] wd, q;
    assign wd = {dq_in[DATA_W+i], dq_in[i*BYTE_W +: BYTE_W]};
    zt_sram_lane #(.AW(AW), .W(LANE_W)) u_lane (
      .clk(clk), .adv(adv), .we(s2_wr && s2_mask[i]),
      .waddr(s2_addr), .wdata(wd),
      .re(s1_rd), .raddr(s1_addr), .q(q)
    );
    assign dq_out[i*BYTE_W +: BYTE_W] = q[BYTE_W-1:0];
    assign dq_out[DATA_W+i]           = q[BYTE_W];
  end

  zt_sram_outctl u_outctl (
    .clk(clk), .rst(rst), .adv(adv), .s1_rd(s1_rd), .s2_wr(s2_wr),
    .out_en_n(out_en_n), .rd_phase(rd_phase), .dq_oe(dq_oe)
  );

  // R8: a deselect sampled at a recognized edge drops drive one recognized edge later
  a_r8_deselect_pipe: assert property (@(posedge clk) disable iff (rst)
    (adv && !sel) ##1 adv |=> !dq_oe);
endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int PERIOD = 10;
  localparam int AW = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [1:0]  cmd;   // 0 deselect, 1 read, 2 write
    logic [3:0]  adr;
    logic [3:0]  msk;   // lane_wr_n
    logic [35:0] din;
    logic        eoe;
    logic [35:0] eq;
  } vec_t;

  localparam logic [35:0] DA = 36'h4_0102_0304;
  localparam logic [35:0] DB = 36'h9_1122_3344;
  localparam logic [35:0] DC = 36'hF_AABB_CCDD;
  localparam logic [35:0] DD = 36'hA_DEAD_BEEF;
  localparam logic [35:0] DE = 36'h8_7700_0000;
  localparam logic [35:0] M2A = 36'h5_0102_03DD;
  localparam logic [35:0] M2B = 36'hD_7702_03DD;

  localparam vec_t VEC [NV] = '{
    '{2'd2, 4'd2, 4'b0000, 36'h0, 1'b0, 36'h0},  // W a2 full
    '{2'd2, 4'd1, 4'b0000, 36'h0, 1'b0, 36'h0},  // W a1 full
    '{2'd2, 4'd2, 4'b1110, DA,    1'b0, 36'h0},  // W a2 lane0; DA lands in a2
    '{2'd1, 4'd2, 4'b1111, DB,    1'b0, 36'h0},  // R3: write phase hi-Z; DB lands in a1
    '{2'd1, 4'd1, 4'b1111, DC,    1'b1, M2A},    // R10: lane0 bypass from DC
    '{2'd2, 4'd3, 4'b0000, 36'h0, 1'b1, DB},     // R4: read->write
    '{2'd1, 4'd3, 4'b1111, 36'h0, 1'b0, 36'h0},  // R4: write->read
    '{2'd0, 4'd0, 4'b1111, DD,    1'b1, DD},     // R10: full bypass
    '{2'd1, 4'd2, 4'b1111, 36'h0, 1'b0, 36'h0},  // R8: deselect
    '{2'd2, 4'd2, 4'b0111, 36'h0, 1'b1, M2A},    // W a2 lane3
    '{2'd1, 4'd1, 4'b1111, 36'h0, 1'b0, 36'h0},
    '{2'd1, 4'd2, 4'b0000, DE,    1'b1, DB},     // R6: mask here ignored
    '{2'd0, 4'd0, 4'b1111, 36'h0, 1'b1, M2B},    // R5/R6: only lane3 changed
    '{2'd0, 4'd0, 4'b1111, 36'h0, 1'b0, 36'h0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en_n = 1'b0;
  logic sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0;
  logic wr_n = 1'b1;
  logic [3:0] lane_wr_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic out_en_n = 1'b0;
  logic [35:0] dq_in = '0;
  logic [35:0] dq_out;
  logic dq_oe;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  zt_sram #(.AW(AW)) u_zt_sram (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .out_en_n(out_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dq_oe=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check36(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dq_out=%h expected %h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, pass one rising edge, return at the next falling edge.
  task automatic cyc(input logic [2:0] en, input logic wn, input logic [3:0] a,
                     input logic [3:0] m, input logic [35:0] d);
    {sel1_n, sel2, sel3_n} = en;
    wr_n = wn;
    addr = AW'(a);
    lane_wr_n = m;
    dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  localparam logic [2:0] EN_ON  = 3'b010;
  localparam logic [2:0] EN_OFF = 3'b110;

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    rst = 1'b0;
    check1("R11 reset state", dq_oe, 1'b0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VEC[k];
      cyc((v.cmd == 2'd0) ? EN_OFF : EN_ON, (v.cmd != 2'd2), v.adr, v.msk, v.din);
      check1($sformatf("R4 row %0d oe", k), dq_oe, v.eoe);
      if (v.eoe) check36($sformatf("R2 row %0d data", k), dq_out, v.eq);
    end

    // R5: a write with no lanes selected leaves a1 unchanged
    cyc(EN_ON, 1'b0, 4'd1, 4'hF, '0);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, 36'hF_FFFF_FFFF);
    cyc(EN_ON, 1'b1, 4'd1, 4'hF, '0);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    check1("R5 empty write readback oe", dq_oe, 1'b1);
    check36("R5 empty write readback", dq_out, DB);

    // R8: each inactive select deselects; R1: all active selects
    cyc(3'b000, 1'b1, 4'd1, 4'hF, '0);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    check1("R8 sel2 low", dq_oe, 1'b0);
    cyc(3'b011, 1'b1, 4'd1, 4'hF, '0);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    check1("R8 sel3_n high", dq_oe, 1'b0);
    cyc(EN_ON, 1'b1, 4'd1, 4'hF, '0);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    check1("R1 selected read oe", dq_oe, 1'b1);
    check36("R1 selected read data", dq_out, DB);

    // R9: asynchronous output enable
    out_en_n = 1'b1;
    #1;
    check1("R9 oe high releases bus", dq_oe, 1'b0);
    out_en_n = 1'b0;
    #1;
    check1("R9 oe low drives bus", dq_oe, 1'b1);
    #(PERIOD/2 - 2);
    @(negedge clk);

    // R7: suspension freezes the pipeline
    cyc(EN_ON, 1'b1, 4'd3, 4'hF, '0);
    check1("R7 read issued", dq_oe, 1'b0);
    clk_en_n = 1'b1;
    cyc(EN_ON, 1'b0, 4'd3, 4'h0, 36'h0_0000_0000);
    cyc(EN_ON, 1'b0, 4'd3, 4'h0, 36'h0_0000_0000);
    check1("R7 frozen read not advanced", dq_oe, 1'b0);
    clk_en_n = 1'b0;
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    check1("R7 resumed read oe", dq_oe, 1'b1);
    check36("R7 resumed read data", dq_out, DD);
    clk_en_n = 1'b1;
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    check1("R7 suspend is not deselect", dq_oe, 1'b1);
    check36("R7 output held", dq_out, DD);
    clk_en_n = 1'b0;
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    check1("R7 deselect after resume", dq_oe, 1'b0);
    cyc(EN_ON, 1'b1, 4'd3, 4'hF, '0);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    check36("R7 no write while suspended", dq_out, DD);

    // R11: reset mid-stream drops the pending read
    cyc(EN_ON, 1'b1, 4'd1, 4'hF, '0);
    rst = 1'b1;
    cyc(EN_ON, 1'b1, 4'd1, 4'hF, '0);
    rst = 1'b0;
    check1("R11 reset clears read phase", dq_oe, 1'b0);
    cyc(EN_OFF, 1'b1, 4'd0, 4'hF, '0);
    check1("R11 reset clears stage valid", dq_oe, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule